// File: doc/BRIEF.md
# Prescaled Compare Timer

A 32-bit up-counter with a single compare channel, programmed through a word-wide register bus. The bus has an address, a write strobe, write data and a combinational read-data return. A clock-enable input drives a power-of-two prescaler. Each prescaled tick advances the counter by one. When the counter reaches a programmable modulo value, the next tick takes it back to zero.

The compare channel has a software-compare mode. In that mode it latches a status flag when a tick carries the counter onto the programmed channel value. Software clears the flag by writing one to it. An interrupt line mirrors the flag while the channel interrupt enable is set. Typical use is as a free-running system tick source: the modulo is left at all ones, and the channel value is reprogrammed relative to the live count to schedule the next event.

Top module: `presc_cmp_timer`

## Requirements
- R1: After reset, every register reads back zero, except the modulo, which reads 0xFFFFFFFF. The irq output is low.
- R2: The counter holds its value whenever the counter-mode field (control bits 4:3) is not 01. Writing zero to the control register stops counting.
- R3: While counting, the counter changes only on cycles where cnt_en is high. With prescale field p (control bits 2:0), it advances once per 2^p enabled cycles.
- R4: The prescaler is held clear while counting is off. After the control write that enables counting, the first increment comes after exactly 2^p enabled cycles.
- R5: A tick taken while the counter equals the modulo value loads zero.
- R6: Any write to the counter offset clears the count at that clock edge, and this takes priority over a tick. A read of the counter returns the live value.
- R7: The register offsets are control 0x10, counter 0x14, modulo 0x18, status 0x1C, channel control 0x20 and channel value 0x24. Each reads back what was written, and unmapped offsets read zero.
- R8: With the channel mode field (channel control bits 5:2) equal to 4, status bit 0 sets on the tick that moves the counter onto the channel value.
- R9: With any other channel mode value, the flag never sets.
- R10: Writing status with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R11: irq is high exactly when the flag is set and the channel interrupt enable (channel control bit 6) is 1.
- R12: When a match and a write-one-to-clear happen at the same edge, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Counter clock enable feeding the prescaler |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Channel interrupt request |

## Verification
A wrong prescaler phase shows up as a counter value that is off by one when read on the first tick boundary after enabling, which is 2^p cycles after the write. A wrong compare or clear decision appears in the status read and on irq at the very edge where the counter lands on the channel value. Because of that, the bench samples the counter and the flag on the exact cycles around each tick. A missed set priority is visible immediately after the colliding write, as a zero flag.

// File: rtl/presc_cmp_timer.sv
module presc_cmp_timer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  localparam int DIV_W = (1 << PS_W) - 1;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_MOD   = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_CHCTL = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_CHVAL = ADDR_W'(8'h24);
  localparam logic [3:0] MODE_SWCMP = 4'h4;

  logic [PS_W-1:0]   ps_q;
  logic [1:0]        cmod_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] count_q, mod_q, chval_q;
  logic [3:0]        chmode_q;
  logic              chie_q, flag_q;

  logic counting, tick, cnt_wr, match;
  logic [DIV_W-1:0]  div_last;
  logic [DATA_W-1:0] inc_val;

  assign counting = (cmod_q == 2'b01);
  assign div_last = ~({DIV_W{1'b1}} << ps_q);
  assign tick     = counting & cnt_en & (div_q == div_last);
  assign cnt_wr   = wr_en & (addr == A_CNT);
  assign inc_val  = (count_q == mod_q) ? '0 : count_q + 1'b1;
  assign match    = tick & ~cnt_wr & (chmode_q == MODE_SWCMP) & (inc_val == chval_q);
  assign irq      = flag_q & chie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q     <= '0;
      cmod_q   <= '0;
      mod_q    <= '1;
      chval_q  <= '0;
      chmode_q <= '0;
      chie_q   <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:  begin ps_q <= wr_data[PS_W-1:0]; cmod_q <= wr_data[4:3]; end
        A_MOD:   mod_q <= wr_data;
        A_CHCTL: begin chmode_q <= wr_data[5:2]; chie_q <= wr_data[6]; end
        A_CHVAL: chval_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             div_q <= '0;
    else if (!counting)     div_q <= '0;
    else if (cnt_en)        div_q <= tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (cnt_wr)  count_q <= '0;
    else if (tick)    count_q <= inc_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       flag_q <= 1'b0;
    else if (match)                                   flag_q <= 1'b1;
    else if (wr_en && addr == A_STAT && wr_data[0])   flag_q <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_CTRL:  rd_data[4:0] = {cmod_q, ps_q};
      A_CNT:   rd_data = count_q;
      A_MOD:   rd_data = mod_q;
      A_STAT:  rd_data[0] = flag_q;
      A_CHCTL: rd_data[6:2] = {chie_q, chmode_q};
      A_CHVAL: rd_data = chval_q;
      default: rd_data = '0;
    endcase
  end

endmodule

module presc_cmp_timer_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] count_q,
  input logic [DATA_W-1:0] mod_q,
  input logic [DATA_W-1:0] chval_q,
  input logic [3:0]        chmode_q,
  input logic [1:0]        cmod_q,
  input logic              flag_q,
  input logic              tick
);
  logic wr_cnt, wr_clr;
  assign wr_cnt = wr_en && addr == ADDR_W'(8'h14);
  assign wr_clr = wr_en && addr == ADDR_W'(8'h1C) && wr_data[0];

  p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmod_q != 2'b01 && !wr_cnt) |=> count_q == $past(count_q));

  p_step_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != $past(count_q) && !$past(wr_cnt)) |-> $past(cnt_en));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count_q == mod_q && !wr_cnt) |=> count_q == '0);

  p_flag_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (count_q == chval_q && $past(chmode_q) == 4'h4));

  p_clear_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(wr_clr));
endmodule

bind presc_cmp_timer presc_cmp_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .addr(addr), .wr_en(wr_en),
  .wr_data(wr_data), .count_q(count_q), .mod_q(mod_q), .chval_q(chval_q),
  .chmode_q(chmode_q), .cmod_q(cmod_q), .flag_q(flag_q), .tick(tick)
);

// File: tb/presc_cmp_timer_test.sv
`timescale 1ns/1ps
module presc_cmp_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  presc_cmp_timer uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop_and_clear();
    wr(8'h10, 32'h0);
    wr(8'h14, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h10, v); check("R1 ctrl", v, 0);
    rd(8'h14, v); check("R1 count", v, 0);
    rd(8'h18, v); check("R1 modulo", v, 32'hFFFF_FFFF);
    rd(8'h1C, v); check("R1 status", v, 0);
    rd(8'h20, v); check("R1 chctrl", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
    rd(8'h30, v); check("R7 unmapped", v, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    cnt_en = 1'b1;
    wait_edges(10);
    rd(8'h14, v); check("R2 ctrl zero holds", v, 0);
    wr(8'h10, 32'h10);
    wait_edges(10);
    rd(8'h14, v); check("R2 mode 10 holds", v, 0);
    rd(8'h10, v); check("R7 ctrl readback", v, 32'h10);
    wr(8'h10, 32'h0);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    wr(8'h10, 32'h08);
    wait_edges(5);
    rd(8'h14, v); check("R3 div1", v, 5);
    stop_and_clear();
    wr(8'h10, 32'h0B);
    wait_edges(7);
    rd(8'h14, v); check("R4 before first tick", v, 0);
    wait_edges(1);
    rd(8'h14, v); check("R4 first tick", v, 1);
    wait_edges(16);
    rd(8'h14, v); check("R3 div8", v, 3);
    cnt_en = 1'b0;
    wait_edges(20);
    rd(8'h14, v); check("R3 cnt_en low", v, 3);
    cnt_en = 1'b1;
    stop_and_clear();
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(8'h18, 32'd4);
    rd(8'h18, v); check("R7 modulo readback", v, 4);
    wr(8'h10, 32'h08);
    wait_edges(4);
    rd(8'h14, v); check("R5 at modulo", v, 4);
    wait_edges(1);
    rd(8'h14, v); check("R5 wrap", v, 0);
    wait_edges(2);
    rd(8'h14, v); check("R5 after wrap", v, 2);
    stop_and_clear();
    wr(8'h18, 32'hFFFF_FFFF);
  endtask

  task automatic t_cnt_write();
    logic [31:0] v;
    wr(8'h10, 32'h08);
    wait_edges(10);
    rd(8'h14, v); check("R6 live", v, 10);
    wr(8'h14, 32'h1234);
    rd(8'h14, v); check("R6 write clears", v, 0);
    wait_edges(3);
    rd(8'h14, v); check("R6 resumes", v, 3);
    stop_and_clear();
  endtask

  task automatic t_compare();
    logic [31:0] v;
    wr(8'h24, 32'd6);
    wr(8'h20, 32'h10);
    wr(8'h10, 32'h08);
    wait_edges(5);
    rd(8'h1C, v); check("R8 before match", v, 0);
    wait_edges(1);
    rd(8'h1C, v); check("R8 match", v, 1);
    check("R11 irq masked", {31'b0, irq}, 0);
    wr(8'h20, 32'h50);
    check("R11 irq enabled", {31'b0, irq}, 1);
    rd(8'h20, v); check("R7 chctrl readback", v, 32'h50);
    wr(8'h1C, 32'h0);
    rd(8'h1C, v); check("R10 write zero", v, 1);
    wr(8'h1C, 32'h1);
    rd(8'h1C, v); check("R10 write one", v, 0);
    check("R11 irq cleared", {31'b0, irq}, 0);
    stop_and_clear();
  endtask

  task automatic t_modes();
    logic [31:0] v;
    wr(8'h24, 32'd3);
    wr(8'h20, 32'h48);
    wr(8'h10, 32'h08);
    wait_edges(6);
    rd(8'h1C, v); check("R9 mode 2 no flag", v, 0);
    check("R9 irq", {31'b0, irq}, 0);
    stop_and_clear();
    wr(8'h20, 32'h40);
    wr(8'h10, 32'h08);
    wait_edges(6);
    rd(8'h1C, v); check("R9 mode 0 no flag", v, 0);
    stop_and_clear();
  endtask

  task automatic t_priority();
    logic [31:0] v;
    wr(8'h24, 32'd4);
    wr(8'h20, 32'h10);
    wr(8'h1C, 32'h1);
    wr(8'h10, 32'h08);
    wait_edges(3);
    wr(8'h1C, 32'h1);
    rd(8'h1C, v); check("R12 set wins", v, 1);
    wr(8'h1C, 32'h1);
    rd(8'h1C, v); check("R12 later clear", v, 0);
    stop_and_clear();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_edges(3);
    rst_n = 1'b1;
    wait_edges(1);
    t_reset();
    t_disabled();
    t_prescale();
    t_wrap();
    t_cnt_write();
    t_compare();
    t_modes();
    t_priority();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule